// File: doc/BRIEF.md
# Keyed-Restart Countdown Watchdog

This block is a countdown watchdog that sits on a plain 32-bit register bus made of an address, a write enable, write data and a combinational read-data return. Software loads a reload value, then sets the enable bit in the control register to start the count. To keep the system alive, software must write a fixed 16-bit key to the restart register at regular intervals. Each valid write copies the reload value back into the counter.

The counter drops by one on each cycle in which `tick_i` is high, so the integrator chooses the time base. If the count runs out, the block does three things. It sets a sticky timeout flag, it clears its own enable so that it does not start again, and it drives a reset-request output for a programmable number of clock cycles. The system reset logic that consumes the request is outside this block.

All eight register slots are 32-bit words on 4-byte boundaries. Any access that is unaligned or lies outside the eight words reads as zero and changes nothing.

Top module: `wdt_top`

## Requirements
- R1: After reset, the count (word 0x00) and the reload value (0x04) both read 0x03EF1480. Control (0x0C) and timeout status (0x10) read 0, the pulse width (0x18) reads 0xFF, and `rst_req_o` is low.
- R2: Reads of the restart word (0x08), the clear word (0x14), the spare word 0x1C, any address with nonzero bits [1:0], and any address at or above 0x20 return 0. Writes to these addresses have no effect, and neither do writes to the count word 0x00.
- R3: A write to 0x08 is a valid restart only when bits [15:0] equal 0x4755. Bits [31:16] are not compared, and any other low half is ignored.
- R4: A valid restart loads the count from the reload value one cycle later, whether the watchdog is enabled or not. An enabled watchdog keeps counting from the new value.
- R5: Control bit 0 is the enable. Writing 1 while disabled loads the count from the reload value and starts it. Writing 0 while enabled freezes the count. Writing 1 while already enabled changes nothing.
- R6: While enabled, the count decreases by exactly one on each cycle with `tick_i` high. It holds on all other cycles.
- R7: When `tick_i` is high, the watchdog is enabled and the count is 1 or 0, the count becomes 0, control bit 0 clears and timeout status bit 0 sets. After that, ticks no longer change the count.
- R8: Writing a word with bit 0 set to 0x14 clears timeout status bit 0. A write with bit 0 clear has no effect. If an expiry happens in the same cycle as a clear, the flag ends up set.
- R9: `rst_req_o` rises in the cycle after an expiry and stays high for exactly the number of clock cycles held in the width register (8 bits, at 0x18). With a width of 0, no pulse appears.
- R10: A write to the reload register does not change the current count.
- R11: A valid restart or a write to the control word takes priority over a tick in the same cycle, and no decrement happens in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Countdown step enable |
| addr_i | input | 12 | Byte address of the register access |
| we_i | input | 1 | Write strobe, sampled on the rising clock edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| rst_req_o | output | 1 | Reset request pulse |

## Verification
Read data is combinational, so a register read shows the state left by the previous rising edge within the same cycle. Any write or tick therefore becomes visible one cycle later: this holds for count updates, enable changes, the timeout flag and the start of the reset request. The bench drives inputs and samples outputs at the falling edge. Before each rising edge it advances a reference model by exactly one step, so every output is compared against the model state that belongs to that cycle. The pulse length is checked cycle by cycle as the model's pulse counter runs down.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned DATA_W = 32;
  localparam logic [15:0] RESTART_KEY = 16'h4755;
  localparam logic [DATA_W-1:0] RELOAD_RST = 32'h03EF1480;

  typedef enum logic [2:0] {
    W_COUNT   = 3'd0,
    W_RELOAD  = 3'd1,
    W_RESTART = 3'd2,
    W_CTRL    = 3'd3,
    W_TSTAT   = 3'd4,
    W_TCLR    = 3'd5,
    W_WIDTH   = 3'd6,
    W_SPARE   = 3'd7
  } word_e;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned PW_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] count_i,
  input  logic              en_i,
  input  logic              expire_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] reload_o,
  output logic [PW_W-1:0]   width_o,
  output logic              restart_o,
  output logic              en_wr_o,
  output logic              en_val_o
);
  logic  in_map, wr_ok, clr;
  word_e word;
  logic  flag_q;
  logic [DATA_W-1:0] reload_q;
  logic [PW_W-1:0]   width_q;

  assign in_map    = (addr_i[1:0] == 2'b00) && (addr_i[ADDR_W-1:5] == '0);
  assign word      = word_e'(addr_i[4:2]);
  assign wr_ok     = we_i && in_map;
  assign restart_o = wr_ok && (word == W_RESTART) && (wdata_i[15:0] == RESTART_KEY);
  assign en_wr_o   = wr_ok && (word == W_CTRL);
  assign en_val_o  = wdata_i[0];
  assign clr       = wr_ok && (word == W_TCLR) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= RELOAD_RST;
      width_q  <= '1;
      flag_q   <= 1'b0;
    end else begin
      if (wr_ok && word == W_RELOAD) reload_q <= wdata_i;
      if (wr_ok && word == W_WIDTH)  width_q  <= wdata_i[PW_W-1:0];
      if (expire_i)  flag_q <= 1'b1;
      else if (clr)  flag_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (in_map) begin
      unique case (word)
        W_COUNT:  rdata_o = count_i;
        W_RELOAD: rdata_o = reload_q;
        W_CTRL:   rdata_o = {{(DATA_W-1){1'b0}}, en_i};
        W_TSTAT:  rdata_o = {{(DATA_W-1){1'b0}}, flag_q};
        W_WIDTH:  rdata_o = {{(DATA_W-PW_W){1'b0}}, width_q};
        default:  rdata_o = '0;
      endcase
    end
  end

  assign reload_o = reload_q;
  assign width_o  = width_q;

  a_r8_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> rdata_o[0] || (word != W_TSTAT) || !in_map || flag_q);
  a_r10_reload_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && word == W_RELOAD) |=> reload_q == $past(wdata_i));
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              restart_i,
  input  logic              en_wr_i,
  input  logic              en_val_i,
  input  logic [DATA_W-1:0] reload_i,
  output logic [DATA_W-1:0] count_o,
  output logic              en_o,
  output logic              expire_o
);
  logic [DATA_W-1:0] count_q;
  logic              en_q;
  logic              bus_op;

  assign bus_op   = restart_i || en_wr_i;
  assign expire_o = en_q && tick_i && !bus_op && (count_q <= 32'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= RELOAD_RST;
      en_q    <= 1'b0;
    end else if (restart_i) begin
      count_q <= reload_i;
    end else if (en_wr_i) begin
      if (en_val_i && !en_q) count_q <= reload_i;
      en_q <= en_val_i;
    end else if (expire_o) begin
      count_q <= '0;
      en_q    <= 1'b0;  // no rearm after expiry
    end else if (en_q && tick_i) begin
      count_q <= count_q - 32'd1;
    end
  end

  assign count_o = count_q;
  assign en_o    = en_q;

  a_r4_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> count_q == $past(reload_i));
  a_r6_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && tick_i && !bus_op && count_q > 32'd1) |=> count_q == $past(count_q) - 32'd1);
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !bus_op) |=> $stable(count_q));
  a_r7_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !en_q && count_q == '0);
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int unsigned PW_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            expire_i,
  input  logic [PW_W-1:0] width_i,
  output logic            rst_req_o
);
  logic [PW_W-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              left_q <= '0;
    else if (expire_i)        left_q <= width_i;
    else if (left_q != '0)    left_q <= left_q - PW_W'(1);
  end

  assign rst_req_o = (left_q != '0);

  a_r9_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && width_i != '0) |=> rst_req_o);
  a_r9_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> $past(expire_i));
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned PW_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rst_req_o
);
  logic [DATA_W-1:0] count, reload;
  logic [PW_W-1:0]   width;
  logic              en, expire, restart, en_wr, en_val;

  wdt_regs #(.ADDR_W(ADDR_W), .PW_W(PW_W)) u_regs (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i,
    .count_i(count), .en_i(en), .expire_i(expire),
    .rdata_o, .reload_o(reload), .width_o(width),
    .restart_o(restart), .en_wr_o(en_wr), .en_val_o(en_val)
  );

  wdt_core u_core (
    .clk_i, .rst_ni, .tick_i,
    .restart_i(restart), .en_wr_i(en_wr), .en_val_i(en_val),
    .reload_i(reload), .count_o(count), .en_o(en), .expire_o(expire)
  );

  wdt_pulse #(.PW_W(PW_W)) u_pulse (
    .clk_i, .rst_ni, .expire_i(expire), .width_i(width), .rst_req_o
  );

  a_r1_quiet_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> !$rose(rst_req_o) || $past(expire));
endmodule

// File: tb/wdt_top_test.sv
module wdt_top_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        rst_req_o;

  int checks = 0;
  int fails  = 0;

  logic [31:0] m_cnt, m_rel;
  logic        m_en, m_flag;
  logic [7:0]  m_w, m_pw;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  wdt_top uut (.clk_i, .rst_ni, .tick_i, .addr_i, .we_i, .wdata_i, .rdata_o, .rst_req_o);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [11:0] a);
    if (a[1:0] != 2'b00 || a[11:5] != '0) return 32'h0;
    case (a[4:2])
      3'd0: return m_cnt;
      3'd1: return m_rel;
      3'd3: return {31'h0, m_en};
      3'd4: return {31'h0, m_flag};
      3'd6: return {24'h0, m_w};
      default: return 32'h0;
    endcase
  endfunction

  task automatic m_step(input logic we, input logic [11:0] a, input logic [31:0] d, input logic tk);
    logic ok, rs, ew, clr, ex;
    ok  = we && a[1:0] == 2'b00 && a[11:5] == '0;
    rs  = ok && a[4:2] == 3'd2 && d[15:0] == 16'h4755;
    ew  = ok && a[4:2] == 3'd3;
    clr = ok && a[4:2] == 3'd5 && d[0];
    ex  = m_en && tk && !rs && !ew && m_cnt <= 32'd1;
    if (ex) m_pw = m_w; else if (m_pw != 0) m_pw = m_pw - 8'd1;
    if (ex) m_flag = 1'b1; else if (clr) m_flag = 1'b0;
    if (rs) m_cnt = m_rel;
    else if (ew) begin
      if (d[0] && !m_en) m_cnt = m_rel;
      m_en = d[0];
    end else if (ex) begin m_cnt = 0; m_en = 1'b0; end
    else if (m_en && tk) m_cnt = m_cnt - 32'd1;
    if (ok && a[4:2] == 3'd1) m_rel = d;
    if (ok && a[4:2] == 3'd6) m_w = d[7:0];
  endtask

  task automatic cyc(input logic we, input logic [11:0] a, input logic [31:0] d,
                     input logic tk, input string req);
    @(negedge clk_i);
    we_i = we; addr_i = a; wdata_i = d; tick_i = tk;
    #1;
    chk(rdata_o, m_read(a), req);
    chk({31'h0, rst_req_o}, {31'h0, m_pw != 0}, {req, " rst_req"});
    m_step(we, a, d, tk);
  endtask

  task automatic rd(input logic [11:0] a, input string req);
    cyc(1'b0, a, 32'h0, 1'b0, req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_cnt = 32'h03EF1480; m_rel = 32'h03EF1480; m_en = 0; m_flag = 0; m_w = 8'hFF; m_pw = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state, literal expectations
    @(negedge clk_i); addr_i = 12'h000; #1; chk(rdata_o, 32'h03EF1480, "R1 count");
    addr_i = 12'h004; #1; chk(rdata_o, 32'h03EF1480, "R1 reload");
    addr_i = 12'h00C; #1; chk(rdata_o, 32'h0, "R1 ctrl");
    addr_i = 12'h018; #1; chk(rdata_o, 32'h0000_00FF, "R1 width");
    chk({31'h0, rst_req_o}, 32'h0, "R1 rst_req");

    // R2 ignored writes and zero reads
    cyc(1, 12'h000, 32'h1234, 0, "R2 count write");
    cyc(1, 12'h01C, 32'hFFFF_FFFF, 0, "R2 spare write");
    cyc(1, 12'h005, 32'h1, 0, "R2 unaligned write");
    cyc(1, 12'h024, 32'h1, 0, "R2 outside write");
    cyc(1, 12'h10C, 32'h1, 0, "R2 alias write");
    rd(12'h000, "R2 count kept"); rd(12'h00C, "R2 ctrl kept");
    rd(12'h008, "R2 restart read"); rd(12'h014, "R2 clear read");
    rd(12'h01C, "R2 spare read"); rd(12'h006, "R2 unaligned read"); rd(12'h040, "R2 outside read");
    chk(rdata_o, 32'h0, "R2 outside literal");

    // R5 enable, R6 ticks, R10 reload write keeps count
    cyc(1, 12'h00C, 32'h1, 0, "R5 enable");
    cyc(0, 12'h000, 0, 1, "R6 tick"); cyc(0, 12'h000, 0, 1, "R6 tick");
    rd(12'h000, "R6 count");
    chk(rdata_o, 32'h03EF147E, "R6 literal");
    cyc(1, 12'h004, 32'd5, 1, "R10 reload write");
    rd(12'h000, "R10 count unchanged");
    cyc(1, 12'h00C, 32'h1, 1, "R11 enable again with tick");
    rd(12'h000, "R5 no reload on 1->1");

    // R3 key checks, R4 restart
    cyc(1, 12'h008, 32'h0000_4756, 0, "R3 bad key");
    rd(12'h000, "R3 bad key ignored");
    cyc(1, 12'h008, 32'hABCD_4755, 1, "R3 key with upper bits");
    rd(12'h000, "R4 restart loaded");
    chk(rdata_o, 32'd5, "R4 literal");

    // R7 expiry, R9 pulse, R8 clear
    for (int i = 0; i < 6; i++) cyc(0, 12'h000, 0, 1, "R7 run down");
    rd(12'h010, "R7 flag"); rd(12'h00C, "R7 enable cleared");
    cyc(0, 12'h000, 0, 1, "R7 no rearm");
    for (int i = 0; i < 260; i++) rd(12'h010, "R9 pulse");
    cyc(1, 12'h014, 32'h2, 0, "R8 clear bit0 zero");
    rd(12'h010, "R8 flag kept");
    cyc(1, 12'h014, 32'h1, 0, "R8 clear");
    rd(12'h010, "R8 flag cleared");

    // R9 zero width, R5 disable freezes
    cyc(1, 12'h018, 32'h0, 0, "R9 width zero");
    cyc(1, 12'h004, 32'd2, 0, "R9 reload");
    cyc(1, 12'h00C, 32'h1, 0, "R5 enable");
    for (int i = 0; i < 6; i++) cyc(0, 12'h010, 0, 1, "R9 no pulse");
    cyc(1, 12'h004, 32'd50, 0, "R5 reload");
    cyc(1, 12'h00C, 32'h1, 0, "R5 enable");
    cyc(0, 12'h000, 0, 1, "R6 tick");
    cyc(1, 12'h00C, 32'h0, 1, "R11 disable with tick");
    for (int i = 0; i < 4; i++) cyc(0, 12'h000, 0, 1, "R5 frozen");
    cyc(1, 12'h018, 32'd3, 0, "R9 width 3");

    // Random mix
    for (int i = 0; i < 6000; i++) begin
      logic [11:0] a;
      logic [31:0] d;
      logic        w;
      int          sel;
      sel = int'($urandom_range(0, 15));
      a = {7'h0, 3'(sel % 8), 2'b00};
      if (sel == 14) a = 12'h0022;
      if (sel == 15) a = 12'h0003;
      d = $urandom;
      if (a == 12'h004) d = 32'($urandom_range(0, 20));
      if (a == 12'h018) d = 32'($urandom_range(0, 6));
      if (a == 12'h008 && $urandom_range(0, 1) == 1) d[15:0] = 16'h4755;
      w = ($urandom_range(0, 3) == 0);
      cyc(w, a, d, $urandom_range(0, 1) == 1, "R4/R6/R7/R9 random");
    end

    @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule